// File: doc/BRIEF.md
# Deep Sleep Wake-Up Controller

This block steps a device into a deep sleep state and out of it again. A sleep request moves it from run mode through a single entry cycle, in which any wake line that is already active cancels the attempt, and then into sleep. While it sleeps it watches six wake lines. The first enabled line to assert ends the sleep. The block records that line in a one-hot status register, sets a sticky exit flag, and holds a reset request for a fixed number of cycles. After that the device restarts from its reset vector.

Each completed entry clears the status register, so software never has to clear it. Entry also sends a one-cycle clear pulse to the deep-sleep watchdog counter. Events seen outside the sleep state never reach the status register. Only a software strobe clears the exit flag.

Top module: `dsw_ctrl`

## Requirements
- R1: After reset `wake_status` is 0, and `ds_flag`, `rst_req`, `asleep` and `wdt_clr` are all low.
- R2: A `sleep_req` seen in run mode with no pending wake line leads to one entry cycle, and `asleep` rises on the second clock edge after the request.
- R3: A completed entry sets `wake_status` to 0 and raises `wdt_clr` for exactly one cycle, the first sleep cycle.
- R4: If an effective wake line is active during the entry cycle, the controller goes back to run mode. No sleep, no `wdt_clr` pulse, no change to `wake_status` and no reset request follow.
- R5: While asleep, an effective wake line moves the controller to wake-reset. `rst_req` is then high for exactly RST_CYCLES (4) cycles, after which the controller is in run mode. Bit order of `wake_src`, `wake_en` and `wake_status`: 0 reset pin, 1 power-on, 2 clock alarm, 3 external interrupt, 4 watchdog time-out, 5 ultra-low-power wake.
- R6: If several effective lines assert in the same cycle, only the lowest-numbered one is recorded, as a single set bit in `wake_status`.
- R7: Lines 2 to 5 count only when their `wake_en` bit is 1. Lines 0 and 1 wake the block whatever their enable bit says.
- R8: `ds_flag` is set on every wake from sleep and stays set until a `flag_clr` strobe clears it. A set in the same cycle wins over the clear.
- R9: Once a wake has been recorded, lines that assert later do not change `wake_status`.
- R10: Wake lines that are active in run mode leave `wake_status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to enter deep sleep (acted on in run mode) |
| wake_src | input | 6 | Wake lines, bit order as in R5 |
| wake_en | input | 6 | Per-line enables; bits 0 and 1 ignored |
| flag_clr | input | 1 | Software clear strobe for `ds_flag` |
| wake_status | output | 6 | One-hot record of the line that ended sleep |
| ds_flag | output | 1 | Sticky deep-sleep-exit flag |
| rst_req | output | 1 | Power-on-style reset request |
| asleep | output | 1 | High while in the sleep state |
| wdt_clr | output | 1 | One-cycle deep-sleep watchdog clear pulse |

## Verification
Some rules are checked by the assertions on every cycle. The status register is never more than one-hot, it holds steady in run and wake-reset, and it is zero after each completed entry. An abort never produces a watchdog pulse. The exit flag never drops without a clear strobe. The priority grant always points at an effective line. Other behaviour can only be shown by the bench's scenarios. These are the full sweep of every line pattern against every enable pattern, the exact length of the reset request, the abort path, and the fact that early and late events are ignored.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  localparam int unsigned N_SRC = 6;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } dsw_state_t;
endpackage

// File: rtl/dsw_prio.sv
module dsw_prio #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] lower;
  assign lower[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign lower[i+1] = lower[i] | req[i];
    assign grant[i]   = req[i] & ~lower[i];
  end
  assign any = lower[N];

  // R6: at most one grant, and only on a requesting line
  a_r6_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r7_grant_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
endmodule

// File: rtl/dsw_seq.sv
module dsw_seq
  import dsw_pkg::*;
#(
  parameter int unsigned N          = 6,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep_req,
  input  logic         pend,
  input  logic [N-1:0] grant,
  input  logic         flag_clr,
  output logic [N-1:0] wake_status,
  output logic         ds_flag,
  output logic         rst_req,
  output logic         asleep,
  output logic         wdt_clr
);
  localparam int unsigned CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(RST_CYCLES - 1);

  dsw_state_t st;
  logic [CW-1:0] cnt;
  logic wake_now;

  assign wake_now = (st == ST_SLEEP) && pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_RUN;
      cnt         <= '0;
      wake_status <= '0;
      wdt_clr     <= 1'b0;
    end else begin
      wdt_clr <= 1'b0;
      unique case (st)
        ST_RUN:   if (sleep_req) st <= ST_ENTER;
        ST_ENTER: begin
          if (pend) begin
            st <= ST_RUN;
          end else begin
            st          <= ST_SLEEP;
            wake_status <= '0;
            wdt_clr     <= 1'b1;
          end
        end
        ST_SLEEP: begin
          if (pend) begin
            st          <= ST_WAKE;
            wake_status <= grant;
            cnt         <= '0;
          end
        end
        ST_WAKE: begin
          if (cnt == CNT_LAST) st <= ST_RUN;
          else                 cnt <= cnt + 1'b1;
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ds_flag <= 1'b0;
    else if (wake_now) ds_flag <= 1'b1;
    else if (flag_clr) ds_flag <= 1'b0;
  end

  assign rst_req = (st == ST_WAKE);
  assign asleep  = (st == ST_SLEEP);

  a_r3_clear_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ENTER && !pend) |=> (wake_status == '0 && wdt_clr));
  a_r4_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ENTER && pend) |=> (!wdt_clr && !asleep && !rst_req));
  a_r6_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_status));
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_flag && !flag_clr) |=> ds_flag);
  a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN || st == ST_WAKE) |=> $stable(wake_status));
  a_r5_wake_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wake_now |=> (rst_req && ds_flag && wake_status != '0));
endmodule

// File: rtl/dsw_ctrl.sv
module dsw_ctrl
  import dsw_pkg::*;
#(
  parameter int unsigned          RST_CYCLES  = 4,
  parameter logic [N_SRC-1:0]     ALWAYS_MASK = 6'b000011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [N_SRC-1:0] wake_src,
  input  logic [N_SRC-1:0] wake_en,
  input  logic             flag_clr,
  output logic [N_SRC-1:0] wake_status,
  output logic             ds_flag,
  output logic             rst_req,
  output logic             asleep,
  output logic             wdt_clr
);
  logic [N_SRC-1:0] eff;
  logic [N_SRC-1:0] grant;
  logic             pend;

  assign eff = wake_src & (wake_en | ALWAYS_MASK);

  dsw_prio #(.N(N_SRC)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (eff),
    .grant (grant),
    .any   (pend)
  );

  dsw_seq #(.N(N_SRC), .RST_CYCLES(RST_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .pend        (pend),
    .grant       (grant),
    .flag_clr    (flag_clr),
    .wake_status (wake_status),
    .ds_flag     (ds_flag),
    .rst_req     (rst_req),
    .asleep      (asleep),
    .wdt_clr     (wdt_clr)
  );
endmodule

// File: tb/tb_dsw_ctrl.sv
module tb_dsw_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0;
  logic [5:0] wake_src = '0;
  logic [5:0] wake_en = '0;
  logic       flag_clr = 1'b0;
  logic [5:0] wake_status;
  logic       ds_flag, rst_req, asleep, wdt_clr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dsw_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_src(wake_src),
    .wake_en(wake_en), .flag_clr(flag_clr), .wake_status(wake_status),
    .ds_flag(ds_flag), .rst_req(rst_req), .asleep(asleep), .wdt_clr(wdt_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sleep entry from run, no sources active; ends at negedge in first sleep cycle
  task automatic go_sleep();
    @(negedge clk) sleep_req = 1'b1;
    @(negedge clk) sleep_req = 1'b0;
    chk(!asleep, "R2 entry cycle", asleep, 0);
    @(negedge clk);
    chk(asleep, "R2 asleep", asleep, 1);
    chk(wake_status == 0, "R3 status cleared", wake_status, 0);
    chk(wdt_clr, "R3 wdt pulse", wdt_clr, 1);
  endtask

  // call at negedge while asleep; wakes with src, checks the reset window
  task automatic wake_with(input logic [5:0] src, input logic [5:0] exp_st, input logic [5:0] late);
    wake_src = src;
    @(negedge clk) wake_src = late;
    chk(wdt_clr == 0, "R3 pulse one cycle", wdt_clr, 0);
    chk(wake_status == exp_st, "R6 recorded source", wake_status, exp_st);
    chk(ds_flag, "R8 flag set", ds_flag, 1);
    for (int k = 0; k < 4; k++) begin
      chk(rst_req, "R5 reset held", rst_req, 1);
      @(negedge clk);
    end
    wake_src = '0;
    chk(!rst_req && !asleep, "R5 reset released", rst_req, 0);
    chk(wake_status == exp_st, "R9 later source ignored", wake_status, exp_st);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(wake_status == 0 && !ds_flag && !rst_req && !asleep && !wdt_clr,
        "R1 reset state", {wake_status, ds_flag, rst_req, asleep, wdt_clr}, 0);
    rst_n = 1'b1;

    // R10: sources in run mode do not touch status
    @(negedge clk) wake_src = 6'h3f;
    @(negedge clk) wake_src = 6'h00;
    chk(wake_status == 0 && !rst_req, "R10 run-mode event", wake_status, 0);

    // sweep every source pattern against every enable pattern (R6, R7)
    for (int e = 0; e < 64; e++) begin
      for (int s = 1; s < 64; s++) begin
        logic [5:0] eff;
        logic [5:0] exp_st;
        wake_en = 6'(e);
        eff = 6'(s) & (6'(e) | 6'b000011);
        exp_st = eff & (~eff + 6'd1);
        go_sleep();
        if (eff == 0) begin
          wake_src = 6'(s);
          @(negedge clk) wake_src = '0;
          chk(asleep && !rst_req && wake_status == 0, "R7 disabled ignored",
              wake_status, 0);
          wake_with(6'b000001, 6'b000001, 6'b000010);
        end else begin
          wake_with(6'(s), exp_st, 6'b000001);
        end
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        chk(!ds_flag, "R8 flag cleared", ds_flag, 0);
      end
    end

    // R8: flag stays set without a clear
    wake_en = 6'h3f;
    go_sleep();
    wake_with(6'b000100, 6'b000100, 6'b0);
    repeat (5) @(negedge clk);
    chk(ds_flag, "R8 flag sticky", ds_flag, 1);

    // R4: pending enabled source during entry aborts
    wake_src = 6'b001000;
    @(negedge clk) sleep_req = 1'b1;
    @(negedge clk) sleep_req = 1'b0;
    @(negedge clk);
    chk(!asleep && !wdt_clr && !rst_req, "R4 abort to run", asleep, 0);
    chk(wake_status == 6'b000100, "R4 status untouched", wake_status, 6'b000100);
    repeat (2) @(negedge clk);
    chk(!asleep && !rst_req, "R4 stays in run", rst_req, 0);
    wake_src = '0;

    // R4 vs R7: disabled source during entry does not abort
    wake_en = 6'b000000;
    wake_src = 6'b100000;
    go_sleep();
    wake_src = '0;
    wake_with(6'b000010, 6'b000010, 6'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule